// File: doc/BRIEF.md
# Multiplexer-Tree Thermometer Decoder

This block turns the (2^N - 1)-bit thermometer word coming out of a bank of comparators into an N-bit binary count. It uses no adders and no lookup table. It works by successive halving. The top output bit is the middle comparator itself. That bit then steers a bank of 2:1 multiplexers, which passes either the upper or the lower half of the word on to the next stage. The middle bit of the half that survives becomes the next output bit. This repeats until the window is a single bit, which gives the least significant bit.

Each bit decision can optionally be followed by a register. With those registers the decoder accepts a new word every clock and has a fixed latency of N cycles, and already-decided upper bits travel alongside the shrinking window so that all bits leave together. Without them the whole tree is combinational and only the output is registered. Because the decoder only looks at one comparator per output bit, an isolated wrong comparator disturbs the result only if it is one of the positions that get probed. When it is, the error size follows a fixed rule.

Top module: `thermo_mux_decoder`

## Requirements
- R1: For a clean thermometer word whose lowest c bits are 1 and whose other bits are 0, bin_o equals c. This holds for every c from 0 to 2^N - 1.
- R2: For any input word, bin_o[N-1] equals therm_i bit 2^(N-1) - 1 (zero-based), once the latency has elapsed.
- R3: Take a clean word of count c and invert exactly one bit at position p. The probe positions of c are floor(c / 2^(k+1)) * 2^(k+1) + 2^k - 1 for k = 0 to N-1. If p is not one of them, bin_o equals c. If it is, bin_o equals p when p < c and p + 1 when p >= c.
- R4: A single inverted bit next to the transition (p = c - 1 or p = c) gives an output that differs from c by at most one.
- R5: With PIPE = 1 the result for the word presented before rising edge t appears after rising edge t + N - 1, and a new word is accepted on every clock. With PIPE = 0 it appears after edge t.
- R6: rst is synchronous and active high. Every rising edge with rst high drives bin_o to 0, whatever the input.
- R7: While therm_i holds one value, bin_o stays constant once the latency has passed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| therm_i | input | 2^N - 1 | Comparator word, bit 0 the lowest threshold |
| bin_o | output | N | Registered binary count |

## Verification
The hardest case to reach is a bubble that lands exactly on one of the few probe positions of the current count. Only N of the 2^N - 1 bit positions are ever examined for a given count, so an arbitrary corruption almost always goes unnoticed. The stimulus pairs a random count with a random flip position for the exact-outcome rule. It also sweeps every count with flips placed directly beside the transition. Both decoders are streamed with a new word every clock, so any stage that drifts out of alignment with the bits it carries shows up as a wrong count at the fixed latency.

// File: rtl/thermo_mux_pkg.sv
package thermo_mux_pkg;

  // Cycles from input sample to registered output.
  function automatic int tmd_latency(input int n, input bit pipe);
    return pipe ? n : 1;
  endfunction

  // Width of the window entering halving stage s (stage 0 sees the full word).
  function automatic int tmd_window(input int n, input int s);
    return (1 << (n - s)) - 1;
  endfunction

endpackage

// File: rtl/tmd_pipe_reg.sv
module tmd_pipe_reg #(
  parameter int W  = 8,
  parameter bit EN = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  generate
    if (EN) begin : g_ff
      logic [W-1:0] q_r;
      always_ff @(posedge clk) begin
        if (rst) q_r <= '0;
        else     q_r <= d;
      end
      assign q = q_r;
    end else begin : g_wire
      logic unused_ctl;
      assign unused_ctl = clk ^ rst;
      assign q = d;
    end
  endgenerate

endmodule

// File: rtl/tmd_halve_stage.sv
// One bit decision: the middle bit of the window is the next output bit and
// steers which half of the window moves on.
module tmd_halve_stage #(
  parameter int IN_W = 63,
  parameter int NB   = 5,
  parameter int POS  = 4,
  parameter bit REG  = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [IN_W-1:0]         win_i,
  input  logic [NB-1:0]           bits_i,
  output logic [(IN_W-1)/2-1:0]   win_o,
  output logic [NB-1:0]           bits_o
);

  localparam int HW = (IN_W - 1) / 2;
  localparam int BW = HW + NB;

  logic          pick_hi;
  logic [HW-1:0] half;
  logic [NB-1:0] bits_n;
  logic [BW-1:0] d_bus;
  logic [BW-1:0] q_bus;

  assign pick_hi = win_i[HW];
  assign half    = pick_hi ? win_i[IN_W-1:HW+1] : win_i[HW-1:0];
  assign bits_n  = bits_i | (NB'(pick_hi) << POS);
  assign d_bus   = {half, bits_n};

  tmd_pipe_reg #(.W(BW), .EN(REG)) u_q (
    .clk (clk),
    .rst (rst),
    .d   (d_bus),
    .q   (q_bus)
  );

  assign win_o  = q_bus[BW-1:NB];
  assign bits_o = q_bus[NB-1:0];

endmodule

// File: rtl/thermo_mux_decoder.sv
// Thermometer-to-binary decoder by successive halving. N must be at least 2.
module thermo_mux_decoder
  import thermo_mux_pkg::*;
#(
  parameter int N    = 6,
  parameter bit PIPE = 1'b1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [(1<<N)-2:0]   therm_i,
  output logic [N-1:0]        bin_o
);

  localparam int NB = N - 1;

  generate
    for (genvar i = 0; i < N - 1; i++) begin : g_stage
      localparam int WI = tmd_window(N, i);
      localparam int WO = tmd_window(N, i + 1);

      logic [WI-1:0] win_in;
      logic [NB-1:0] bits_in;
      logic [WO-1:0] win_out;
      logic [NB-1:0] bits_out;

      if (i == 0) begin : g_head
        assign win_in  = therm_i;
        assign bits_in = '0;
      end else begin : g_link
        assign win_in  = g_stage[i-1].win_out;
        assign bits_in = g_stage[i-1].bits_out;
      end

      tmd_halve_stage #(
        .IN_W (WI),
        .NB   (NB),
        .POS  (NB - 1 - i),
        .REG  (PIPE)
      ) u_stage (
        .clk    (clk),
        .rst    (rst),
        .win_i  (win_in),
        .bits_i (bits_in),
        .win_o  (win_out),
        .bits_o (bits_out)
      );
    end
  endgenerate

  // The last window is one bit wide: it is the LSB directly.
  logic [N-1:0] bin_d;
  assign bin_d = {g_stage[N-2].bits_out, g_stage[N-2].win_out[0]};

  tmd_pipe_reg #(.W(N), .EN(1'b1)) u_out (
    .clk (clk),
    .rst (rst),
    .d   (bin_d),
    .q   (bin_o)
  );

endmodule

// File: rtl/tmd_chk.sv
module tmd_chk
  import thermo_mux_pkg::*;
#(
  parameter int N    = 6,
  parameter bit PIPE = 1'b1
) (
  input logic              clk,
  input logic              rst,
  input logic [(1<<N)-2:0] therm_i,
  input logic [N-1:0]      bin_o
);

  localparam int TW  = (1 << N) - 1;
  localparam int LAT = tmd_latency(N, PIPE);
  localparam int MID = (1 << (N - 1)) - 1;

  // h_q: consecutive non-reset edges that saw the same input as last_q.
  logic [TW-1:0] last_q;
  int unsigned   h_q;

  always_ff @(posedge clk) begin
    last_q <= therm_i;
    if (rst)
      h_q <= 0;
    else if (h_q != 0 && therm_i == last_q)
      h_q <= (h_q < LAT + 1) ? h_q + 1 : h_q;
    else
      h_q <= 1;
  end

  function automatic bit is_clean(input logic [TW-1:0] v);
    logic [TW-1:0] ones;
    ones = '1;
    return v == (ones >> (TW - $countones(v)));
  endfunction

  // R6: reset clears the output on the next edge
  p_reset_clear_r6: assert property (@(posedge clk)
    rst |=> bin_o == '0);

  // R1: a clean word decodes to its number of ones
  p_clean_count_r1: assert property (@(posedge clk) disable iff (rst)
    (h_q >= LAT && is_clean(last_q)) |-> (int'(bin_o) == $countones(last_q)));

  // R2: top bit follows the middle comparator
  p_msb_mid_r2: assert property (@(posedge clk) disable iff (rst)
    (h_q >= LAT) |-> (bin_o[N-1] == last_q[MID]));

  // R7: held input gives held output
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (h_q > LAT) |-> $stable(bin_o));

endmodule

bind thermo_mux_decoder tmd_chk #(.N(N), .PIPE(PIPE)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .therm_i (therm_i),
  .bin_o   (bin_o)
);

// File: tb/thermo_mux_decoder_test.sv
// Clock period 4 time units (250 MHz with 1 ns units).
module thermo_mux_decoder_test;

  localparam int N6 = 6;
  localparam int N4 = 4;
  localparam int LAT6 = 6;  // PIPE = 1
  localparam int LAT4 = 1;  // PIPE = 0

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [62:0] t6  = '0;
  logic [14:0] t4  = '0;
  logic [5:0]  b6;
  logic [3:0]  b4;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;
  string phase = "";

  int hk6 [16];
  int he6 [16];
  int hk4 [16];
  int he4 [16];

  always #2 clk = ~clk;

  thermo_mux_decoder #(.N(N6), .PIPE(1'b1)) uut (
    .clk (clk), .rst (rst), .therm_i (t6), .bin_o (b6)
  );

  thermo_mux_decoder #(.N(N4), .PIPE(1'b0)) uut_small (
    .clk (clk), .rst (rst), .therm_i (t4), .bin_o (b4)
  );

  function automatic logic [62:0] clean(input int c);
    logic [62:0] v = '0;
    for (int i = 0; i < 63; i++) if (i < c) v[i] = 1'b1;
    return v;
  endfunction

  // Exact single-flip outcome from the probe-position rule (R3).
  function automatic int flip_expect(input int n, input int c, input int p);
    for (int k = 0; k < n; k++) begin
      int pos;
      pos = ((c >> (k + 1)) << (k + 1)) + (1 << k) - 1;
      if (pos == p) return (p < c) ? p : p + 1;
    end
    return c;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, phase, act, exp);
    end
  endtask

  // kind: 0 clean (R1), 1 random flip (R3), 2 arbitrary MSB (R2), 3 adjacent flip (R4)
  task automatic judge(input int kind, input int exp, input int act, input int n);
    case (kind)
      0: chk("R1", act, exp);
      1: chk("R3", act, exp);
      2: chk("R2", (act >> (n - 1)) & 1, exp);
      3: begin
        int d;
        checks++;
        d = act - exp;
        if (d > 1 || d < -1) begin
          fails++;
          $display("FAIL R4 %s actual=%0d expected=%0d+-1", phase, act, exp);
        end
      end
      default: ;
    endcase
  endtask

  task automatic clear_hist();
    for (int i = 0; i < 16; i++) begin
      hk6[i] = -1; hk4[i] = -1; he6[i] = 0; he4[i] = 0;
    end
  endtask

  // Check what is due this cycle, then present a new word to each decoder.
  task automatic step(input logic [62:0] v6, input int kd6, input int x6,
                      input logic [14:0] v4, input int kd4, input int x4);
    int s6, s4, w;
    @(negedge clk);
    s6 = (cyc + 16 - LAT6) % 16;
    s4 = (cyc + 16 - LAT4) % 16;
    judge(hk6[s6], he6[s6], int'(b6), N6);
    judge(hk4[s4], he4[s4], int'(b4), N4);
    w = cyc % 16;
    hk6[w] = kd6; he6[w] = x6;
    hk4[w] = kd4; he4[w] = x4;
    t6 = v6;
    t4 = v4;
    cyc++;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    t6 = {$urandom, $urandom};
    t4 = 15'($urandom);
    @(negedge clk);
    chk("R6", int'(b6), 0);
    chk("R6", int'(b4), 0);
    repeat (2) @(negedge clk);
    chk("R6", int'(b6), 0);
    chk("R6", int'(b4), 0);
    clear_hist();
    rst = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int c, p, c4, p4, snap6, snap4;
    logic [62:0] v6;
    logic [14:0] v4;
    void'($urandom(32'd20240611));
    clear_hist();

    // R6: reset state
    do_reset();

    // R1: every clean code, rising then falling
    for (int i = 0; i < 64; i++)
      step(clean(i), 0, i, 15'(clean(i % 16)), 0, i % 16);
    for (int i = 63; i >= 0; i--)
      step(clean(i), 0, i, 15'(clean(i % 16)), 0, i % 16);

    // R5: an isolated full-scale word among zeros must land at the fixed latency
    phase = "R5";
    repeat (8) step('0, 0, 0, '0, 0, 0);
    step(clean(63), 0, 63, 15'(clean(15)), 0, 15);
    repeat (8) step('0, 0, 0, '0, 0, 0);
    step(clean(1), 0, 1, 15'(clean(1)), 0, 1);
    step(clean(62), 0, 62, 15'(clean(14)), 0, 14);
    repeat (8) step('0, 0, 0, '0, 0, 0);
    phase = "";

    // R1: random clean codes back to back
    for (int i = 0; i < 200; i++) begin
      c = $urandom_range(63, 0);
      c4 = $urandom_range(15, 0);
      step(clean(c), 0, c, 15'(clean(c4)), 0, c4);
    end

    // R3: one random flipped bit on a random count
    for (int i = 0; i < 400; i++) begin
      c = $urandom_range(63, 0);
      p = $urandom_range(62, 0);
      c4 = $urandom_range(15, 0);
      p4 = $urandom_range(14, 0);
      v6 = clean(c) ^ (63'(1) << p);
      v4 = 15'(clean(c4)) ^ (15'(1) << p4);
      step(v6, 1, flip_expect(N6, c, p), v4, 1, flip_expect(N4, c4, p4));
    end

    // R3: directed flips at the middle comparator on both sides of it
    step(clean(20) ^ (63'(1) << 31), 1, 32, 15'(clean(3)) ^ (15'(1) << 7), 1, 8);
    step(clean(50) ^ (63'(1) << 31), 1, 31, 15'(clean(12)) ^ (15'(1) << 7), 1, 7);

    // R4: flips directly beside the transition
    for (int i = 0; i < 64; i++) begin
      for (int s = 0; s < 2; s++) begin
        int kd4;
        p = i - 1 + s;
        c4 = i % 16;
        p4 = c4 - 1 + s;
        kd4 = (p4 >= 0 && p4 <= 14) ? 3 : -1;
        v4 = (kd4 == 3) ? (15'(clean(c4)) ^ (15'(1) << p4)) : '0;
        if (p >= 0 && p <= 62)
          step(clean(i) ^ (63'(1) << p), 3, i, v4, kd4, c4);
        else
          step('0, -1, 0, v4, kd4, c4);
      end
    end

    // R2: arbitrary words, top bit only
    for (int i = 0; i < 200; i++) begin
      v6 = {$urandom, $urandom};
      v4 = 15'($urandom);
      step(v6, 2, int'(v6[31]), v4, 2, int'(v4[7]));
    end

    // R7: hold an arbitrary word, the output must not move
    v6 = {$urandom, $urandom};
    v4 = 15'($urandom);
    repeat (10) step(v6, 2, int'(v6[31]), v4, 2, int'(v4[7]));
    snap6 = int'(b6);
    snap4 = int'(b4);
    repeat (4) begin
      @(negedge clk);
      chk("R7", int'(b6), snap6);
      chk("R7", int'(b4), snap4);
    end

    // R6: reset in the middle of traffic, then resume
    repeat (3) step(clean(45), 0, 45, 15'(clean(9)), 0, 9);
    do_reset();
    for (int i = 0; i < 20; i++)
      step(clean(63 - i), 0, 63 - i, 15'(clean(15 - (i % 16))), 0, 15 - (i % 16));
    repeat (8) step('0, 0, 0, '0, 0, 0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule